// File: doc/BRIEF.md
# Weak-Ordering Memory Issue Gate

This block sits between an in-order core that emits memory requests and a memory system that may finish them in any order. Each request arrives on a valid/ready port with a transaction ID and a one-bit kind tag that marks it as ordinary data traffic or as a synchronization point. Data requests pass straight through to the downstream issue port and may complete in any order. The gate imposes ordering only at synchronization points.

A synchronization request is held at the input until every data request issued before it has reported completion. Once it issues, it is the only synchronization in flight. All later requests of either kind are held until its completion ID comes back. The gate keeps a count of data requests that are issued but not yet complete, a flag for the synchronization in flight, and the ID of that synchronization. The issue path is combinational from the input: it adds no register stage and no buffer.

Top module: `wo_issue_gate`

## Requirements
- R1: After reset the outstanding-data count is zero and no synchronization is in flight, so a synchronization request is offered downstream (issValid high) in the first cycle it is presented.
- R2: A data request (reqSync = 0) is offered downstream in the same cycle when no synchronization is in flight and the count is below MAX_OUT. issId equals reqId, issSync equals reqSync, and reqReady follows issReady.
- R3: A synchronization request (reqSync = 1) is not offered downstream while the registered outstanding-data count is nonzero.
- R4: While an issued synchronization has not completed, no data request is offered downstream.
- R5: Data completions are accepted in any order, each one lowering the count by one. A waiting synchronization issues in the cycle after the last outstanding completion is received.
- R6: When a data request issues and a data completion arrives in the same cycle, the count stays unchanged.
- R7: When the count equals MAX_OUT, further data requests are stalled. One cycle after a completion they are accepted again.
- R8: Only one synchronization is in flight at a time. A second one waits at the input until the first one's completion ID is returned, so synchronizations stay in program order.
- R9: A completion that arrives with no data outstanding and no synchronization in flight is ignored. The count does not wrap.
- R10: While a synchronization is in flight, a completion whose ID differs from the stored synchronization ID is ignored, and the synchronization stays pending.
- R11: When issReady is low, reqReady is low and no request is accepted, so neither the count nor the pending flag changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Core request present |
| reqReady | output | 1 | Gate accepts the core request this cycle |
| reqSync | input | 1 | Request kind: 1 = synchronization, 0 = data |
| reqId | input | ID_W | Request transaction ID |
| issValid | output | 1 | Request offered to memory |
| issReady | input | 1 | Memory can take a request |
| issSync | output | 1 | Kind of the offered request |
| issId | output | ID_W | ID of the offered request |
| cmpValid | input | 1 | Completion returned by memory |
| cmpId | input | ID_W | ID of the completed request |

## Verification
The main sequence interleaves data bursts, synchronizations and completions. Data completions come back in the reverse of issue order, which shows that the count, not the order, gates the synchronization. A same-cycle issue and completion is followed by a synchronization that must still wait, which separates a held count from a wrongly decremented one. Two synchronizations are sent back to back, and completions with a wrong ID and with no owner are injected, to tell a correct pending flag from one that clears early or a count that underflows. A run of data requests up to MAX_OUT, followed by one more, exposes an off-by-one in the stall limit.

// File: rtl/wo_gate_pkg.sv
package wo_gate_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic incCnt;
    logic decCnt;
    logic setSync;
    logic clrSync;
  } gateStrobe_t;

  // state summary from datapath to control
  typedef struct packed {
    logic cntZero;
    logic cntFull;
    logic syncPend;
    logic cmpHitsSync;
  } gateStatus_t;

endpackage

// File: rtl/wo_gate_ctrl.sv
module wo_gate_ctrl
  import wo_gate_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        reqSync,
  input  logic        issReady,
  input  logic        cmpValid,
  input  gateStatus_t status,
  output logic        reqReady,
  output logic        issValid,
  output gateStrobe_t strobe
);

  logic allowData;
  logic allowSync;
  logic allow;
  logic fire;

  always_comb begin
    allowData = !status.syncPend && !status.cntFull;
    allowSync = !status.syncPend && status.cntZero;
    allow     = reqSync ? allowSync : allowData;
    issValid  = reqValid && allow;
    reqReady  = issReady && allow;
    fire      = issValid && issReady;
  end

  always_comb begin
    strobe.incCnt  = fire && !reqSync;
    strobe.setSync = fire && reqSync;
    strobe.clrSync = cmpValid && status.syncPend && status.cmpHitsSync;
    strobe.decCnt  = cmpValid && !status.syncPend && !status.cntZero;
  end

  // R11
  no_accept_blocked_chk: assert property (@(posedge clk) disable iff (!rstN)
    !issReady |-> !(strobe.incCnt || strobe.setSync));

endmodule

// File: rtl/wo_gate_dpath.sv
module wo_gate_dpath
  import wo_gate_pkg::*;
#(
  parameter int ID_W    = 4,
  parameter int MAX_OUT = 6
) (
  input  logic            clk,
  input  logic            rstN,
  input  gateStrobe_t     strobe,
  input  logic [ID_W-1:0] reqId,
  input  logic [ID_W-1:0] cmpId,
  output gateStatus_t     status
);

  localparam int CNT_W = $clog2(MAX_OUT + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MAX_OUT);

  logic [CNT_W-1:0] cntQ;
  logic [CNT_W-1:0] cntD;
  logic             syncPendQ;
  logic [ID_W-1:0]  syncIdQ;

  always_comb begin
    unique case ({strobe.incCnt, strobe.decCnt})
      2'b10:   cntD = cntQ + 1'b1;
      2'b01:   cntD = cntQ - 1'b1;
      default: cntD = cntQ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntQ      <= '0;
      syncPendQ <= 1'b0;
      syncIdQ   <= '0;
    end else begin
      cntQ <= cntD;
      if (strobe.setSync) begin
        syncPendQ <= 1'b1;
        syncIdQ   <= reqId;
      end else if (strobe.clrSync) begin
        syncPendQ <= 1'b0;
      end
    end
  end

  always_comb begin
    status.cntZero     = (cntQ == '0);
    status.cntFull     = (cntQ >= CNT_MAX);
    status.syncPend    = syncPendQ;
    status.cmpHitsSync = (cmpId == syncIdQ);
  end

  // R3
  sync_wait_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.setSync |-> (cntQ == '0));

  // R4
  data_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    syncPendQ |-> !strobe.incCnt);

  // R8
  one_sync_chk: assert property (@(posedge clk) disable iff (!rstN)
    syncPendQ |-> !strobe.setSync);

  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    cntQ <= CNT_MAX);

  // R6
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.incCnt && strobe.decCnt) |=> $stable(cntQ));

  // R9
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((cntQ == '0) && !strobe.incCnt) |=> (cntQ == '0));

  // R10
  sync_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (syncPendQ && !strobe.clrSync) |=> syncPendQ);

endmodule

// File: rtl/wo_issue_gate.sv
module wo_issue_gate
  import wo_gate_pkg::*;
#(
  parameter int ID_W    = 4,
  parameter int MAX_OUT = 6
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            reqValid,
  output logic            reqReady,
  input  logic            reqSync,
  input  logic [ID_W-1:0] reqId,
  output logic            issValid,
  input  logic            issReady,
  output logic            issSync,
  output logic [ID_W-1:0] issId,
  input  logic            cmpValid,
  input  logic [ID_W-1:0] cmpId
);

  gateStrobe_t strobe;
  gateStatus_t status;

  assign issSync = reqSync;
  assign issId   = reqId;

  wo_gate_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqSync  (reqSync),
    .issReady (issReady),
    .cmpValid (cmpValid),
    .status   (status),
    .reqReady (reqReady),
    .issValid (issValid),
    .strobe   (strobe)
  );

  wo_gate_dpath #(.ID_W(ID_W), .MAX_OUT(MAX_OUT)) u_dpath (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .reqId  (reqId),
    .cmpId  (cmpId),
    .status (status)
  );

endmodule

// File: tb/sim_wo_issue_gate.sv
`timescale 1ns/1ps
module sim_wo_issue_gate;

  localparam int ID_W    = 4;
  localparam int MAX_OUT = 6;
  localparam int NVEC    = 21;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            reqValid = 1'b0;
  logic            reqSync = 1'b0;
  logic [ID_W-1:0] reqId = '0;
  logic            issReady = 1'b0;
  logic            cmpValid = 1'b0;
  logic [ID_W-1:0] cmpId = '0;
  logic            reqReady;
  logic            issValid;
  logic            issSync;
  logic [ID_W-1:0] issId;

  int nChk  = 0;
  int nFail = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  wo_issue_gate #(.ID_W(ID_W), .MAX_OUT(MAX_OUT)) u0 (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqReady(reqReady), .reqSync(reqSync), .reqId(reqId),
    .issValid(issValid), .issReady(issReady), .issSync(issSync), .issId(issId),
    .cmpValid(cmpValid), .cmpId(cmpId)
  );

  // row: reqValid, reqSync, reqId[4], issReady, cmpValid, cmpId[4], expIssValid, expReqReady
  localparam logic [13:0] VEC [0:NVEC-1] = '{
    14'b1_0_0001_1_0_0000_1_1, // 0  R2 data issue, cnt->1
    14'b1_0_0010_1_0_0000_1_1, // 1  R2 data issue, cnt->2
    14'b1_1_0011_1_0_0000_0_0, // 2  R3 sync held
    14'b1_1_0011_1_1_0010_0_0, // 3  R5 completion of later data first
    14'b1_1_0011_1_1_0001_0_0, // 4  R5 last completion, cnt->0
    14'b1_1_0011_1_0_0000_1_1, // 5  R5 sync issues
    14'b1_0_0100_1_0_0000_0_0, // 6  R4 data held
    14'b1_0_0100_1_1_1001_0_0, // 7  R10 wrong ID completion
    14'b1_0_0100_1_0_0000_0_0, // 8  R10 still pending
    14'b1_0_0100_1_1_0011_0_0, // 9  R4 sync completes
    14'b1_0_0100_1_0_0000_1_1, // 10 R4 data free again, cnt->1
    14'b1_0_0101_1_1_0100_1_1, // 11 R6 issue+completion, cnt stays 1
    14'b1_1_0110_1_0_0000_0_0, // 12 R6 sync still held
    14'b1_1_0110_1_1_0101_0_0, // 13 R5 cnt->0
    14'b1_1_0110_0_0_0000_1_0, // 14 R11 backpressure
    14'b1_1_0110_1_0_0000_1_1, // 15 R8 first sync issues
    14'b1_1_0111_1_0_0000_0_0, // 16 R8 second sync waits
    14'b1_1_0111_1_1_0110_0_0, // 17 R8 first completes
    14'b1_1_0111_1_0_0000_1_1, // 18 R8 second sync issues
    14'b0_0_0000_1_1_0111_0_0, // 19 R8 second completes
    14'b0_0_0000_1_1_1000_0_1  // 20 R9 stray completion
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic s, input logic [ID_W-1:0] id,
                       input logic rdy, input logic cv, input logic [ID_W-1:0] cid);
    @(negedge clk);
    reqValid = v; reqSync = s; reqId = id;
    issReady = rdy; cmpValid = cv; cmpId = cid;
    #1;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      nChk++; nFail++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R1 reset state: sync offered at once (no accept since issReady low)
    drive(1, 1, 4'hA, 0, 0, 0);
    chk("R1 issValid", {7'd0, issValid}, 8'd1);
    chk("R1 reqReady", {7'd0, reqReady}, 8'd0);

    for (int i = 0; i < NVEC; i++) begin
      logic [13:0] v;
      v = VEC[i];
      drive(v[13], v[12], v[11:8], v[7], v[6], v[5:2]);
      chk($sformatf("R2-R11 row%0d issValid", i), {7'd0, issValid}, {7'd0, v[1]});
      chk($sformatf("R2-R11 row%0d reqReady", i), {7'd0, reqReady}, {7'd0, v[0]});
      if (v[1]) begin
        chk($sformatf("R2 row%0d issId", i), {4'd0, issId}, {4'd0, v[11:8]});
        chk($sformatf("R2 row%0d issSync", i), {7'd0, issSync}, {7'd0, v[12]});
      end
    end

    // R9 and R7: count is zero after the stray completion, MAX_OUT data accepted
    for (int k = 0; k < MAX_OUT; k++) begin
      drive(1, 0, ID_W'(k), 1, 0, 0);
      chk("R9 R7 fill accepted", {7'd0, issValid}, 8'd1);
    end
    drive(1, 0, 4'hE, 1, 0, 0);
    chk("R7 full stall", {7'd0, issValid}, 8'd0);
    chk("R7 full stall ready", {7'd0, reqReady}, 8'd0);
    drive(1, 0, 4'hE, 1, 1, 4'h0);
    chk("R7 stall during completion", {7'd0, issValid}, 8'd0);
    drive(1, 0, 4'hE, 1, 0, 0);
    chk("R7 accepted after completion", {7'd0, issValid}, 8'd1);

    // R1 reset in mid-state clears count
    drive(0, 0, 0, 0, 0, 0);
    rstN = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    drive(1, 1, 4'hB, 1, 0, 0);
    chk("R1 sync after reset", {7'd0, issValid}, 8'd1);
    drive(0, 0, 0, 0, 0, 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

endmodule